// File: doc/BRIEF.md
# External Bus Yield Arbiter

This block sits on a processor core's side of a shared external memory bus. It decides when the bus is handed to an outside master. The outside master asks for the bus on an active-low request line, which can change at any time relative to the core clock. The block watches whether the core has an external access in flight, counting wait-stated cycles as part of that access. It hands the bus over only at the boundary of an access. That boundary can fall inside an instruction, so an instruction that makes two external accesses is split, with the bus granted between the two.

While the bus is granted away, the block floats the core's address, data and strobe drivers and normally halts the core. In a run-on mode the core keeps executing. It is halted only when it reaches an access that needs the external bus. Whenever the core wants an external cycle that it cannot run, a hang output tells the other masters to give the bus back. Once the bus returns, the pending access runs first, and only then does the hang output drop. The arbiter has a reset of its own and keeps serving requests while the core is held in reset or is booting.

Top module: `xbus_yield`

## Requirements
- R1: While `rstN` is low and right after it rises, `busGrant`=0, `drvEn`=1, `coreHalt`=0 and `busHang`=0.
- R2: With `accBusy`=0 and `goMode`=0, when `busReqN` is held low, `busGrant` goes to 1, `drvEn` to 0 and `coreHalt` to 1 at the third rising edge that samples it low (two synchronizer edges, then one state edge).
- R3: If `accBusy` is 1 when the synchronized request is seen, grant is withheld, `drvEn` stays 1 and `coreHalt` is 1 for as long as `accBusy` stays 1, for any length (an eight-cycle wait-stated access included). Grant is given at the first edge that samples `accBusy`=0.
- R4: A further pending access (`accReq`=1) after the in-flight one ends does not delay the grant. The bus is granted at that access boundary, with `busHang`=1 and `coreHalt`=1.
- R5: With `goMode`=1, granting the bus leaves `coreHalt`=0 as long as `accReq`=0. `coreHalt` rises at the edge that samples `accReq`=1.
- R6: When `busReqN` returns high, the third rising edge that samples it high drops `busGrant` and sets `drvEn`=1. If no access is pending, `coreHalt`=0 and `busHang`=0.
- R7: While `coreRstN` is low, requests are still granted and released with the same timing, and `accReq` is ignored: `busHang` stays 0 and no pending access is held after release.
- R8: While granted, `busHang` equals `accReq` (with `coreRstN`=1) as sampled at the previous edge.
- R9: If an access is pending when the grant is released, `busHang` stays 1 with `drvEn`=1 and `coreHalt`=0 until an edge samples `accBusy`=1. That edge drops `busHang`.
- R10: `busGrant` and `drvEn` are never both 1, and never both 0, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset of the arbiter itself |
| coreRstN | input | 1 | Active-low core reset, observed only |
| busReqN | input | 1 | Active-low bus request from the outside master, asynchronous |
| accBusy | input | 1 | An external access, wait states included, occupies the bus this cycle |
| accReq | input | 1 | The core needs an external access |
| goMode | input | 1 | 1: the core keeps running while the bus is granted away |
| busGrant | output | 1 | Bus granted to the outside master |
| drvEn | output | 1 | Enable for the core's address, data and strobe drivers |
| coreHalt | output | 1 | Stall the core |
| busHang | output | 1 | The core is stalled waiting for the bus |

## Verification
A wrong internal state shows at the ports on the very edge it is entered, because every output is registered from the next state. A state machine stuck in the deferral state would show `coreHalt`=1 with no grant, long after `accBusy` fell. A lost pending access would drop `busHang` at release instead of holding it until `accBusy` rises. A slip in the request path moves grant and release off the third-edge timing by whole cycles. The scoreboard catches that on the first cycle where the timing differs.

// File: rtl/xbus_yield_pkg.sv
package xbus_yield_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0001,
    ST_DEFER = 4'b0010,
    ST_GIVEN = 4'b0100,
    ST_OWED  = 4'b1000
  } yieldState_t;

  typedef struct packed {
    logic grant;
    logic halt;
    logic hang;
  } yieldStrobes_t;

endpackage

// File: rtl/xbus_yield_ctrl.sv
module xbus_yield_ctrl
  import xbus_yield_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqSync,
  input  logic          accBusy,
  input  logic          accReq,
  input  logic          coreRstN,
  input  logic          goMode,
  output yieldStrobes_t strobes
);

  yieldState_t curState;
  yieldState_t nextState;
  logic        accNeed;

  // a core held in reset asks for nothing
  assign accNeed = accReq & coreRstN;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE: begin
        if (reqSync) nextState = accBusy ? ST_DEFER : ST_GIVEN;
      end
      ST_DEFER: begin
        if (!reqSync)     nextState = ST_IDLE;
        else if (!accBusy) nextState = ST_GIVEN;
      end
      ST_GIVEN: begin
        if (!reqSync) nextState = accNeed ? ST_OWED : ST_IDLE;
      end
      ST_OWED: begin
        if (accBusy || !accNeed) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  always_comb begin
    strobes.grant = (nextState == ST_GIVEN);
    strobes.halt  = (nextState == ST_DEFER) ||
                    ((nextState == ST_GIVEN) && (!goMode || accNeed));
    strobes.hang  = ((nextState == ST_GIVEN) && accNeed) || (nextState == ST_OWED);
  end

endmodule

// File: rtl/xbus_yield_dp.sv
module xbus_yield_dp
  import xbus_yield_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReqN,
  input  yieldStrobes_t strobes,
  output logic          reqSync,
  output logic          busGrant,
  output logic          drvEn,
  output logic          coreHalt,
  output logic          busHang
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= busReqN;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign reqSync = ~syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busGrant <= 1'b0;
      drvEn    <= 1'b1;
      coreHalt <= 1'b0;
      busHang  <= 1'b0;
    end else begin
      busGrant <= strobes.grant;
      drvEn    <= ~strobes.grant;
      coreHalt <= strobes.halt;
      busHang  <= strobes.hang;
    end
  end

endmodule

// File: rtl/xbus_yield.sv
module xbus_yield
  import xbus_yield_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic coreRstN,
  input  logic busReqN,
  input  logic accBusy,
  input  logic accReq,
  input  logic goMode,
  output logic busGrant,
  output logic drvEn,
  output logic coreHalt,
  output logic busHang
);

  yieldStrobes_t strobes;
  logic          reqSync;

  xbus_yield_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqSync  (reqSync),
    .accBusy  (accBusy),
    .accReq   (accReq),
    .coreRstN (coreRstN),
    .goMode   (goMode),
    .strobes  (strobes)
  );

  xbus_yield_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busReqN  (busReqN),
    .strobes  (strobes),
    .reqSync  (reqSync),
    .busGrant (busGrant),
    .drvEn    (drvEn),
    .coreHalt (coreHalt),
    .busHang  (busHang)
  );

endmodule

// File: rtl/xbus_yield_chk.sv
module xbus_yield_chk (
  input logic clk,
  input logic rstN,
  input logic coreRstN,
  input logic accBusy,
  input logic accReq,
  input logic goMode,
  input logic busGrant,
  input logic drvEn,
  input logic coreHalt,
  input logic busHang
);

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    busGrant != drvEn); // R10

  AST_GRANT_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> !$past(accBusy)); // R3

  AST_RUNON_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && $past(goMode) && !$past(accReq && coreRstN)) |-> !coreHalt); // R5

  AST_RELEASE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busGrant) |-> (drvEn && !coreHalt)); // R6

  AST_HANG_NOT_IN_CORE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busHang) |-> $past(coreRstN)); // R7

  AST_HANG_TRACKS_NEED: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant && $past(busGrant)) |-> (busHang == $past(accReq && coreRstN))); // R8

  AST_OWED_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (busHang && !busGrant) |-> (drvEn && !coreHalt)); // R9

endmodule

bind xbus_yield xbus_yield_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .coreRstN (coreRstN),
  .accBusy  (accBusy),
  .accReq   (accReq),
  .goMode   (goMode),
  .busGrant (busGrant),
  .drvEn    (drvEn),
  .coreHalt (coreHalt),
  .busHang  (busHang)
);

// File: tb/xbus_yield_tb.sv
`timescale 1ns/1ps
module xbus_yield_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreRstN = 1'b1;
  logic busReqN = 1'b1;
  logic accBusy = 1'b0;
  logic accReq = 1'b0;
  logic goMode = 1'b0;
  logic busGrant, drvEn, coreHalt, busHang;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  g;
    logic  h;
    logic  hg;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  xbus_yield u_dut (
    .clk(clk), .rstN(rstN), .coreRstN(coreRstN), .busReqN(busReqN),
    .accBusy(accBusy), .accReq(accReq), .goMode(goMode),
    .busGrant(busGrant), .drvEn(drvEn), .coreHalt(coreHalt), .busHang(busHang)
  );

  task automatic report;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // driver: one cycle of stimulus plus the outputs expected after its edge
  task automatic cyc(input bit req, input bit busy, input bit acc, input bit go,
                     input bit crst, input bit eg, input bit eh, input bit ehg,
                     input string tag);
    expItem_t it;
    @(negedge clk);
    busReqN  = ~req;
    accBusy  = busy;
    accReq   = acc;
    goMode   = go;
    coreRstN = crst;
    it.g = eg; it.h = eh; it.hg = ehg; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      expItem_t it;
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (busGrant !== it.g || drvEn !== ~it.g || coreHalt !== it.h || busHang !== it.hg) begin
          fails++;
          $display("FAIL %s: got grant=%b drv=%b halt=%b hang=%b, expected grant=%b drv=%b halt=%b hang=%b",
                   it.tag, busGrant, drvEn, coreHalt, busHang, it.g, ~it.g, it.h, it.hg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (busGrant !== 1'b0 || drvEn !== 1'b1 || coreHalt !== 1'b0 || busHang !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: got %b%b%b%b, expected 0100", busGrant, drvEn, coreHalt, busHang);
    end
    rstN = 1'b1;
    cyc(0,0,0,0,1, 0,0,0, "R1 after reset");
    cyc(0,0,0,0,1, 0,0,0, "R1 after reset");

    // R2 idle grant, then R6 release
    cyc(1,0,0,0,1, 0,0,0, "R2 sync1");
    cyc(1,0,0,0,1, 0,0,0, "R2 sync2");
    cyc(1,0,0,0,1, 1,1,0, "R2 grant");
    cyc(1,0,0,0,1, 1,1,0, "R2 hold");
    cyc(0,0,0,0,1, 1,1,0, "R6 sync1");
    cyc(0,0,0,0,1, 1,1,0, "R6 sync2");
    cyc(0,0,0,0,1, 0,0,0, "R6 released");
    cyc(0,0,0,0,1, 0,0,0, "R6 idle");

    // R3 eight-cycle wait-stated access defers grant
    cyc(1,1,0,0,1, 0,0,0, "R3 busy1");
    cyc(1,1,0,0,1, 0,0,0, "R3 busy2");
    for (int i = 3; i <= 8; i++) cyc(1,1,0,0,1, 0,1,0, "R3 deferred");
    cyc(1,0,0,0,1, 1,1,0, "R3 grant after access");
    cyc(0,0,0,0,1, 1,1,0, "R6 sync1");
    cyc(0,0,0,0,1, 1,1,0, "R6 sync2");
    cyc(0,0,0,0,1, 0,0,0, "R6 released");

    // R4 split between two accesses, then R9 owed access
    cyc(1,1,1,0,1, 0,0,0, "R4 first access");
    cyc(1,1,1,0,1, 0,0,0, "R4 first access");
    cyc(1,1,1,0,1, 0,1,0, "R4 deferred");
    cyc(1,0,1,0,1, 1,1,1, "R4 granted mid-instruction");
    cyc(0,0,1,0,1, 1,1,1, "R8 hang while granted");
    cyc(0,0,1,0,1, 1,1,1, "R8 hang while granted");
    cyc(0,0,1,0,1, 0,0,1, "R9 owed access held");
    cyc(0,0,1,0,1, 0,0,1, "R9 owed access held");
    cyc(0,1,1,0,1, 0,0,0, "R9 hang drops on access");
    cyc(0,0,0,0,1, 0,0,0, "R9 idle");

    // R5 run-on mode
    cyc(1,0,0,1,1, 0,0,0, "R5 sync1");
    cyc(1,0,0,1,1, 0,0,0, "R5 sync2");
    cyc(1,0,0,1,1, 1,0,0, "R5 granted no halt");
    cyc(1,0,0,1,1, 1,0,0, "R5 still running");
    cyc(1,0,1,1,1, 1,1,1, "R5 halt on external need");
    cyc(1,0,0,1,1, 1,0,0, "R8 need withdrawn");
    cyc(0,0,0,1,1, 1,0,0, "R6 sync1");
    cyc(0,0,0,1,1, 1,0,0, "R6 sync2");
    cyc(0,0,0,1,1, 0,0,0, "R6 released");

    // R7 core held in reset
    cyc(1,0,1,0,0, 0,0,0, "R7 sync1");
    cyc(1,0,1,0,0, 0,0,0, "R7 sync2");
    cyc(1,0,1,0,0, 1,1,0, "R7 granted, need ignored");
    cyc(0,0,1,0,0, 1,1,0, "R7 sync1 release");
    cyc(0,0,1,0,0, 1,1,0, "R7 sync2 release");
    cyc(0,0,1,0,0, 0,0,0, "R7 released, nothing owed");
    cyc(0,0,0,0,1, 0,0,0, "R7 idle");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    report();
    $finish;
  end

endmodule